// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Serial Converter Front End

This block is the digital front end of a four-channel converter. A host writes 16-bit command words into it over a three-wire serial port made of an active-low select, a serial clock and a data line. All three wires are oversampled in the system clock domain. Each channel holds an input register, and that register feeds a converter register. The four converter-register values are the outputs of the block. A command can do one of four things: load one input register, load one input register together with its converter register, move every input register into its converter register at the same moment, or do nothing except set the edge mode of the serial output. An active-low load pin also copies all four input registers into the converter registers. For as long as that pin stays low, the copy repeats on every system clock.

The internal 16-bit shift register keeps its contents from one transaction to the next. During a transaction it shifts the previous word out on the serial output, most significant bit first, while the new word is shifted in. A host can use this to read back the last word, and several devices can be chained so that one word passes through to the next device. The serial output is enabled only while the select line is low.

The frame logic is an FSM with three states:
- ST_IDLE waits for select to fall. Serial-clock edges in this state are ignored. On a select fall it moves to ST_SHIFT.
- ST_SHIFT samples data on each serial-clock rise. When select rises it moves to ST_EXEC if exactly 16 bits were received, and otherwise back to ST_IDLE.
- ST_EXEC issues the held word as a one-cycle command and always returns to ST_IDLE.

Top module: `dacif_quad`

## Requirements
- R1: After reset all four input registers and all four converter registers read zero, `sdo_en` is 0, and the serial output is in falling-edge mode.
- R2: A word is sent MSB first, with bits are sampled on serial-clock rising edges. Bits 15:14 give the channel (0 to 3), bits 13:12 give the control code and bits 11:0 give the data. Control code 00 loads the data into the selected input register and leaves every converter register unchanged.
- R3: Control code 01 loads the data into both the input register and the converter register of the selected channel.
- R4: Control code 10 copies all four input registers into their converter registers at once. Its channel and data fields have no effect on any register.
- R5: Control code 11 changes no channel register. Data bit 0 of this word sets the serial-output mode for later transactions: 0 selects falling-edge mode and 1 selects rising-edge mode.
- R6: A command takes effect only when select rises after exactly 16 serial-clock rising edges. A frame of any other length changes no channel register and no mode.
- R7: While `ldac_n` is low, every converter register takes the value of its input register on every system clock. This includes input values written by a command while the pin is held low.
- R8: Serial-clock edges that occur while select is high do not alter the shift register.
- R9: `sdo_en` is 1 while a transaction is in progress and 0 once select is high.
- R10: The shift register keeps the last word shifted in. In falling-edge mode, just before rising edge k and just before falling edge k of the next transaction, `sdo` equals the bit that stood in the shift register's MSB after k-1 shifts.
- R11: In rising-edge mode, `sdo` takes the current MSB at each rising edge before the shift. Just before falling edge k, `sdo` equals the MSB after k-1 shifts. Just before rising edge k (k ≥ 2), it equals the MSB after k-2 shifts. Before the first rising edge it shows the initial MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low load of all converter registers |
| sdo | output | 1 | Serial data out, the word shifted through |
| sdo_en | output | 1 | Output enable for sdo (high while selected) |
| dac_code | output | 4x12 | Converter-register values, channel 0 in the lowest slice |

## Verification
The assertions assume the following about the serial inputs:
- Each serial wire is steady for several system clocks around each of its edges, so that every edge seen after the synchronizers is clean and single.
- Select does not fall again within the cycle that follows its rise.
- Load-pin activity never coincides with a command issue.

The stimulus meets these conditions by design. Each serial half period lasts eight system clocks, data changes only while the serial clock is low, and the bench pauses after each select rise. Load pulses are placed either in idle gaps or across whole frames.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef enum logic [1:0] {
        CTL_INP  = 2'b00,
        CTL_BOTH = 2'b01,
        CTL_ALL  = 2'b10,
        CTL_NOP  = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01,
        ST_EXEC  = 2'b10
    } frame_st_e;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int          W      = 4,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST[b]}};
                last  <= RST[b];
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
                last  <= chain[STAGES-1];
            end
        end

        assign q[b]      = chain[STAGES-1];
        assign q_prev[b] = last;
    end

endmodule

// File: rtl/dacif_frame.sv
module dacif_frame
    import dacif_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sdi_s,
    input  logic          mode_we,
    input  logic          mode_d,
    output logic          cmd_valid,
    output logic [WW-1:0] cmd_word,
    output logic          sdo,
    output logic          sdo_en
);

    localparam int CW = $clog2(WW + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(WW);
    localparam logic [CW-1:0] CNT_SAT  = CW'(WW + 1);

    frame_st_e     state_q, state_d;
    logic [WW-1:0] sreg_q;
    logic [CW-1:0] cnt_q;
    logic          sdo_q, sdo_en_q, mode_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT: if (cs_rise) state_d = (cnt_q == CNT_FULL) ? ST_EXEC : ST_IDLE;
            ST_EXEC:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q   <= '0;
            cnt_q    <= '0;
            sdo_q    <= 1'b0;
            sdo_en_q <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        cnt_q    <= '0;
                        sdo_q    <= sreg_q[WW-1];
                        sdo_en_q <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        sdo_en_q <= 1'b0;
                    end else begin
                        if (sclk_rise) begin
                            sreg_q <= {sreg_q[WW-2:0], sdi_s};
                            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
                            if (mode_q) sdo_q <= sreg_q[WW-1];
                        end
                        if (sclk_fall && !mode_q) sdo_q <= sreg_q[WW-1];
                    end
                end
                ST_EXEC: begin
                end
                default: begin
                end
            endcase
            if (mode_we) mode_q <= mode_d;
        end
    end

    assign cmd_valid = (state_q == ST_EXEC);
    assign cmd_word  = sreg_q;
    assign sdo       = sdo_q;
    assign sdo_en    = sdo_en_q;

    AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise && cnt_q != CNT_FULL) |=> (state_q != ST_EXEC)); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_SAT); // R6

    AST_IDLE_IGNORES_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cs_fall) |=> $stable(sreg_q)); // R8

    AST_SDO_OFF_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |-> !sdo_en_q); // R9

endmodule

// File: rtl/dacif_chanbank.sv
module dacif_chanbank
    import dacif_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int CHB = 2,
    parameter int WW  = CHB + 2 + DW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [WW-1:0]           cmd_word,
    input  logic                    ldac_act,
    output logic [NCH-1:0][DW-1:0]  dac_code,
    output logic                    mode_we,
    output logic                    mode_d
);

    ctl_e               ctl;
    logic [CHB-1:0]     sel;
    logic [DW-1:0]      data;
    logic [NCH-1:0][DW-1:0] inp_all;

    assign sel  = cmd_word[WW-1 -: CHB];
    assign ctl  = ctl_e'(cmd_word[DW+1:DW]);
    assign data = cmd_word[DW-1:0];

    assign mode_we = cmd_valid && (ctl == CTL_NOP);
    assign mode_d  = data[0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic          hit;
        logic [DW-1:0] inp_r, dac_r;

        assign hit = cmd_valid && (sel == CHB'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inp_r <= '0;
                dac_r <= '0;
            end else begin
                if (hit && (ctl == CTL_INP || ctl == CTL_BOTH)) inp_r <= data;
                if (hit && ctl == CTL_BOTH)                     dac_r <= data;
                else if (cmd_valid && ctl == CTL_ALL)           dac_r <= inp_r;
                else if (ldac_act)                              dac_r <= inp_r;
            end
        end

        assign inp_all[g]  = inp_r;
        assign dac_code[g] = dac_r;
    end

    AST_INP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(inp_all)); // R2

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !ldac_act) |=> $stable(dac_code)); // R3

    AST_LDAC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_act && !cmd_valid) |=> (dac_code == $past(inp_all))); // R7

    AST_ALL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ctl == CTL_ALL) |=> (dac_code == $past(inp_all))); // R4

endmodule

// File: rtl/dacif_quad.sv
module dacif_quad
    import dacif_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 12,
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic                   sdi,
    input  logic                   ldac_n,
    output logic                   sdo,
    output logic                   sdo_en,
    output logic [NCH-1:0][DW-1:0] dac_code
);

    localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WW  = CHB + 2 + DW;

    // bit order: {ldac_n, cs_n, sdi, sclk}
    logic [3:0] s_q, s_prev;

    dacif_sync #(.W(4), .STAGES(STAGES), .RST(4'b1100)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({ldac_n, cs_n, sdi, sclk}),
        .q      (s_q),
        .q_prev (s_prev)
    );

    logic sclk_rise, sclk_fall, cs_fall, cs_rise, ldac_act;
    assign sclk_rise = s_q[0] & ~s_prev[0];
    assign sclk_fall = ~s_q[0] & s_prev[0];
    assign cs_fall   = ~s_q[2] & s_prev[2];
    assign cs_rise   = s_q[2] & ~s_prev[2];
    assign ldac_act  = ~s_q[3];

    logic          cmd_valid, mode_we, mode_d;
    logic [WW-1:0] cmd_word;

    dacif_frame #(.WW(WW)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sdi_s     (s_q[1]),
        .mode_we   (mode_we),
        .mode_d    (mode_d),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .sdo       (sdo),
        .sdo_en    (sdo_en)
    );

    dacif_chanbank #(.NCH(NCH), .DW(DW), .CHB(CHB), .WW(WW)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .ldac_act  (ldac_act),
        .dac_code  (dac_code),
        .mode_we   (mode_we),
        .mode_d    (mode_d)
    );

    AST_EN_DROPS_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_en); // R9

endmodule

// File: tb/test_dacif_quad.sv
module test_dacif_quad;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ldac_n = 1'b1;
    logic sdo, sdo_en;
    logic [3:0][11:0] dac_code;

    always #4 clk = ~clk;

    dacif_quad i_dacif_quad (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .ldac_n(ldac_n), .sdo(sdo), .sdo_en(sdo_en), .dac_code(dac_code)
    );

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_sreg = '0;
    logic        exp_mode = 1'b0;
    logic [11:0] exp_inp [4];
    logic [11:0] exp_dac [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        for (int c = 0; c < 4; c++) chk(tag, 32'(dac_code[c]), 32'(exp_dac[c]));
    endtask

    function automatic void apply_cmd(input logic [15:0] w);
        int c = int'(w[15:14]);
        case (w[13:12])
            2'b00: exp_inp[c] = w[11:0];
            2'b01: begin exp_inp[c] = w[11:0]; exp_dac[c] = w[11:0]; end
            2'b10: for (int i = 0; i < 4; i++) exp_dac[i] = exp_inp[i];
            default: exp_mode = w[0];
        endcase
    endfunction

    function automatic logic [15:0] mkw(input int ch, input int ctl, input int d);
        return {2'(ch), 2'(ctl), 12'(d)};
    endfunction

    task automatic frame(input logic [15:0] w, input int nbits, input bit hold, input string tag);
        logic m = exp_mode;
        logic a1, a2, b;
        if (hold) ldac_n = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        repeat (H) @(negedge clk);
        chk("R9 enable during frame", 32'(sdo_en), 32'd1);
        a1 = exp_sreg[15]; a2 = a1;
        for (int k = 1; k <= nbits; k++) begin
            b = (k <= 16) ? w[16-k] : 1'b0;
            sdi = b;
            repeat (H) @(negedge clk);
            a1 = exp_sreg[15];
            chk(tag, 32'(sdo), 32'((m == 1'b0 || k == 1) ? a1 : a2));
            sclk = 1'b1;
            a2 = a1;
            exp_sreg = {exp_sreg[14:0], b};
            repeat (H) @(negedge clk);
            chk(tag, 32'(sdo), 32'(a2));
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        if (nbits == 16) apply_cmd(w);
        if (hold) begin
            for (int i = 0; i < 4; i++) exp_dac[i] = exp_inp[i];
            ldac_n = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk("R9 enable after frame", 32'(sdo_en), 32'd0);
    endtask

    task automatic ldac_pulse();
        @(negedge clk); ldac_n = 1'b0;
        repeat (4) @(negedge clk); ldac_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 4; i++) exp_dac[i] = exp_inp[i];
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int seed;
        logic [15:0] rw;
        int nb;
        bit hl;
        for (int i = 0; i < 4; i++) begin exp_inp[i] = '0; exp_dac[i] = '0; end
        seed = $urandom(32'd9137);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk_regs("R1 reset");
        chk("R1 enable at reset", 32'(sdo_en), 32'd0);

        // R2 input-only load, converter unchanged
        frame(mkw(1, 0, 12'hABC), 16, 1'b0, "R10 sdo falling");
        chk_regs("R2 input only");
        // R4 transfer all (data field ignored)
        frame(mkw(3, 2, 12'h555), 16, 1'b0, "R10 sdo falling");
        chk_regs("R4 all transfer");
        chk("R4 ch1", 32'(dac_code[1]), 32'h0ABC);
        // R3 load both
        frame(mkw(2, 1, 12'h123), 16, 1'b0, "R10 sdo falling");
        chk_regs("R3 both");
        chk("R3 ch2", 32'(dac_code[2]), 32'h0123);
        // R6 short and long frames discarded
        frame(mkw(0, 1, 12'hFFF), 15, 1'b0, "R10 sdo falling");
        chk_regs("R6 short frame");
        frame(mkw(0, 1, 12'hEEE), 17, 1'b0, "R10 sdo falling");
        chk_regs("R6 long frame");
        // R8 sclk toggles with select high
        sdi = 1'b1;
        for (int t = 0; t < 20; t++) begin
            repeat (H) @(negedge clk); sclk = ~sclk;
        end
        sclk = 1'b0;
        frame(mkw(0, 3, 0), 16, 1'b0, "R8 readback after idle clocks");
        chk_regs("R5 nop falling");
        // R5 switch to rising mode
        frame(mkw(2, 3, 1), 16, 1'b0, "R10 sdo falling");
        chk_regs("R5 nop keeps regs");
        frame(mkw(0, 0, 12'h7A5), 16, 1'b0, "R11 sdo rising");
        chk_regs("R2 input only rising");
        // R7 pulse in idle
        ldac_pulse();
        chk_regs("R7 pulse");
        chk("R7 ch0", 32'(dac_code[0]), 32'h07A5);
        // R7 held low across a frame
        frame(mkw(3, 0, 12'h3C3), 16, 1'b1, "R11 sdo rising");
        chk_regs("R7 held");
        chk("R7 ch3", 32'(dac_code[3]), 32'h03C3);
        // back to falling mode
        frame(mkw(1, 3, 0), 16, 1'b0, "R11 sdo rising");

        for (int it = 0; it < 40; it++) begin
            rw = 16'($urandom);
            nb = ($urandom % 8 == 0) ? (($urandom % 2 == 0) ? 15 : 17) : 16;
            hl = ($urandom % 6 == 0);
            frame(rw, nb, hl, exp_mode ? "R11 sdo rising" : "R10 sdo falling");
            chk_regs(nb == 16 ? "R2 R3 R4 R5 random" : "R6 random odd length");
            if ($urandom % 7 == 0) begin
                ldac_pulse();
                chk_regs("R7 random pulse");
            end
        end
        finish_run();
    end

endmodule